// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the digital model of a synthesizer feedback divider. It counts cycles of a fast input clock and issues one output pulse for every N·P+A of them. Inside are a dual-modulus prescaler that divides by P or by P+1, where P is fixed at 32. Alongside it run a main counter of prescaler cycles, loaded with N, and a swallow counter, loaded with A. Each output period begins with A prescaler cycles at the larger modulus. The remaining N−A prescaler cycles follow at modulus P, so a period lasts (P+1)·A + P·(N−A) = N·P+A input cycles.

New N and A words are offered with a one-cycle load strobe. The block screens each offer against the limits that give gap-free ratio steps: A below P, A below N, and N at least P. These limits restrict the overall ratio to 1024 through 65535. A rejected offer raises an error flag and leaves the held setting as it was. An accepted offer waits until the running period ends, so a period in progress always completes with the ratio it started with.

Top module: `pswallow_divider`

## Requirements
- R1: In steady state the spacing between consecutive output pulses is exactly N·P+A input clock cycles, with P = 32, for the setting in force.
- R2: After synchronous reset is released, the first output pulse is registered on the (N·P+A)-th rising edge counted from the first edge with reset low, using the reset setting N=32, A=0 (1024 cycles).
- R3: Each output pulse on `div_pulse` is high for exactly one input clock cycle.
- R4: An accepted load does not change the output period that is running when it arrives. The new N and A govern the period that starts at the next pulse.
- R5: A load whose values break N ≥ 32, A < 32 or A < N sets `cfg_err` on the cycle after the strobe. The divide ratio in force and the held setting stay unchanged, and later periods keep the old spacing.
- R6: An accepted load clears `cfg_err`.
- R7: The extreme legal settings give the extreme ratios: N=32, A=0 gives 1024 cycles, and N=2047, A=31 gives 65535 cycles.
- R8: While reset is asserted, `div_pulse` and `cfg_err` are low. Reset restores the setting N=32, A=0 whatever was loaded before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| n_word | input | 11 | Main counter setting N offered with the strobe |
| a_word | input | 5 | Swallow counter setting A offered with the strobe |
| ld_stb | input | 1 | One-cycle strobe that offers n_word and a_word |
| div_pulse | output | 1 | Registered output pulse, one cycle wide, once per period |
| cfg_err | output | 1 | High after a rejected offer, cleared by an accepted one or reset |

## Verification
The bench measures pulse spacing at both ends of the legal range, 1024 and 65535 cycles, and at mixed settings with a nonzero swallow count. An off-by-one in modulus selection or counter reload would show there as spacings one prescaler cycle or one input cycle away from N·P+A. It delivers loads in the middle of periods. A divider that reloads immediately would then shorten or stretch the running period instead of the following one. Rejected offers with N below 32 and with A above N must raise the flag and leave the spacing alone. A divider that latched them anyway would change the ratio, and one with a sticky flag would fail to clear it on the next good load. A reset issued after loads must bring back the 1024-cycle default.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // Prescaler low modulus; the high modulus is one larger.
  localparam int PSD_P   = 32;
  localparam int PSD_NW  = 11;
  localparam int PSD_AW  = 5;
  // Setting restored by reset.
  localparam int PSD_N_RST = 32;
  localparam int PSD_A_RST = 0;
endpackage

// File: rtl/psd_cfg_guard.sv
// Screens offered N/A words and holds the pending setting.
module psd_cfg_guard #(
  parameter int P     = 32,
  parameter int NW    = 11,
  parameter int AW    = 5,
  parameter int N_RST = 32,
  parameter int A_RST = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_word,
  input  logic [AW-1:0] a_word,
  input  logic          ld_stb,
  output logic [NW-1:0] pend_n,
  output logic [AW-1:0] pend_a,
  output logic          cfg_err
);
  logic offer_ok;

  always_comb begin
    offer_ok = (int'(n_word) >= P) && (int'(a_word) < P) && (int'(a_word) < int'(n_word));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_n  <= NW'(N_RST);
      pend_a  <= AW'(A_RST);
      cfg_err <= 1'b0;
    end else if (ld_stb) begin
      if (offer_ok) begin
        pend_n  <= n_word;
        pend_a  <= a_word;
        cfg_err <= 1'b0;
      end else begin
        cfg_err <= 1'b1;
      end
    end
  end

  // R5: a rejected offer leaves the held setting untouched and flags it
  p_hold_bad_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_stb && !offer_ok) |=> ($stable(pend_n) && $stable(pend_a) && cfg_err));

  // R6: an accepted offer clears the flag
  p_clear_ok_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_stb && offer_ok) |=> !cfg_err);

  // R7: the held setting always lies inside the gap-free range
  p_legal_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(pend_n) >= P) && (int'(pend_a) < int'(pend_n)) && (int'(pend_a) < P));
endmodule

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: counts down P (high modulus, P+1 cycles) or P-1.
module psd_prescaler #(
  parameter int P = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_hi,
  input  logic next_hi,
  output logic tc
);
  localparam int PCW = $clog2(P + 1);
  localparam logic [PCW-1:0] PC_HI = PCW'(P);
  localparam logic [PCW-1:0] PC_LO = PCW'(P - 1);

  logic [PCW-1:0] pc;

  always_ff @(posedge clk) begin
    if (rst)           pc <= rst_hi ? PC_HI : PC_LO;
    else if (pc == '0) pc <= next_hi ? PC_HI : PC_LO;
    else               pc <= pc - PCW'(1);
  end

  always_comb tc = (pc == '0);

  // R1: the phase counter never exceeds the high-modulus start value
  p_phase_bound_r1: assert property (@(posedge clk) disable iff (rst)
    pc <= PC_HI);

  // R1: after a terminal count the phase restarts at one of the two moduli
  p_phase_restart_r1: assert property (@(posedge clk) disable iff (rst)
    tc |=> (pc == PC_HI || pc == PC_LO));
endmodule

// File: rtl/psd_counters.sv
// Main (N) and swallow (A) counters advanced by prescaler terminal counts.
module psd_counters #(
  parameter int NW    = 11,
  parameter int AW    = 5,
  parameter int N_RST = 32,
  parameter int A_RST = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tc,
  input  logic [NW-1:0] pend_n,
  input  logic [AW-1:0] pend_a,
  output logic          next_hi,
  output logic          div_pulse
);
  logic [NW-1:0] nc;
  logic [AW-1:0] ac;
  logic          last_pre;
  logic          period_end;

  always_comb begin
    last_pre   = (nc == NW'(1));
    period_end = tc && last_pre;
    next_hi    = last_pre ? (pend_a != '0) : (ac > AW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nc        <= NW'(N_RST);
      ac        <= AW'(A_RST);
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= period_end;
      if (tc) begin
        if (last_pre) begin
          nc <= pend_n;
          ac <= pend_a;
        end else begin
          nc <= nc - NW'(1);
          if (ac != '0) ac <= ac - AW'(1);
        end
      end
    end
  end

  // R3: the output pulse lasts a single cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R4: each new period starts from the setting held at the boundary
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    div_pulse |-> (nc == $past(pend_n) && ac == $past(pend_a)));

  // R1: the main counter never runs empty
  p_main_live_r1: assert property (@(posedge clk) disable iff (rst)
    nc != '0);

  // R1: the swallow count never exceeds the main count
  p_swallow_order_r1: assert property (@(posedge clk) disable iff (rst)
    int'(ac) < int'(nc) || ac == '0);
endmodule

// File: rtl/pswallow_divider.sv
// Pulse-swallow divider top: one output pulse per N*P+A input cycles.
module pswallow_divider
  import psd_pkg::*;
#(
  parameter int P     = PSD_P,
  parameter int NW    = PSD_NW,
  parameter int AW    = PSD_AW,
  parameter int N_RST = PSD_N_RST,
  parameter int A_RST = PSD_A_RST
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_word,
  input  logic [AW-1:0] a_word,
  input  logic          ld_stb,
  output logic          div_pulse,
  output logic          cfg_err
);
  localparam logic RST_HI = (A_RST != 0);

  logic [NW-1:0] pend_n;
  logic [AW-1:0] pend_a;
  logic          tc;
  logic          next_hi;

  psd_cfg_guard #(.P(P), .NW(NW), .AW(AW), .N_RST(N_RST), .A_RST(A_RST)) u_guard (
    .clk(clk), .rst(rst), .n_word(n_word), .a_word(a_word), .ld_stb(ld_stb),
    .pend_n(pend_n), .pend_a(pend_a), .cfg_err(cfg_err)
  );

  psd_prescaler #(.P(P)) u_pre (
    .clk(clk), .rst(rst), .rst_hi(RST_HI), .next_hi(next_hi), .tc(tc)
  );

  psd_counters #(.NW(NW), .AW(AW), .N_RST(N_RST), .A_RST(A_RST)) u_cnt (
    .clk(clk), .rst(rst), .tc(tc), .pend_n(pend_n), .pend_a(pend_a),
    .next_hi(next_hi), .div_pulse(div_pulse)
  );

  // R8: outputs are quiet in the cycle after a reset edge
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |=> (!div_pulse && !cfg_err));
endmodule

// File: tb/pswallow_divider_test.sv
module pswallow_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] n_word = '0;
  logic [4:0]  a_word = '0;
  logic        ld_stb = 1'b0;
  logic        div_pulse;
  logic        cfg_err;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  pswallow_divider uut (
    .clk(clk), .rst(rst), .n_word(n_word), .a_word(a_word), .ld_stb(ld_stb),
    .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts rising edges until div_pulse is seen; optional load at edge ld_at.
  task automatic measure(output int cnt, output bit first_hi, output bit err_after,
                         input bit do_ld, input int ld_at, input int ln, input int la);
    cnt = 0; first_hi = 1'b0; err_after = 1'b0;
    while (1) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) first_hi = div_pulse;
      if (do_ld && cnt == ld_at) begin
        n_word = 11'(ln); a_word = 5'(la); ld_stb = 1'b1;
      end
      if (do_ld && cnt == ld_at + 1) begin
        ld_stb = 1'b0; err_after = cfg_err;
      end
      if (div_pulse && cnt > 1) break;
      if (cnt > 70000) break;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ld_stb = 1'b0;
    repeat (3) @(negedge clk);
    chk(div_pulse == 1'b0, "R8 div_pulse in reset", int'(div_pulse), 0);
    chk(cfg_err == 1'b0, "R8 cfg_err in reset", int'(cfg_err), 0);
    rst = 1'b0;
  endtask

  task automatic t_first_after_reset();
    int c; bit fh, ea;
    do_reset();
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 1024, "R2 first pulse after reset", c, 1024);
  endtask

  task automatic t_boundary_loads();
    int c; bit fh, ea;
    measure(c, fh, ea, 1'b1, 200, 2047, 31);
    chk(fh == 1'b0, "R3 pulse width", int'(fh), 0);
    chk(c == 1024, "R4 running period kept", c, 1024);
    measure(c, fh, ea, 1'b1, 300, 100, 7);
    chk(c == 65535, "R7 max ratio N=2047 A=31", c, 65535);
    chk(fh == 1'b0, "R3 pulse width", int'(fh), 0);
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 3207, "R1 N=100 A=7 spacing", c, 3207);
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 3207, "R1 N=100 A=7 repeat", c, 3207);
  endtask

  task automatic t_rejected_offers();
    int c; bit fh, ea;
    measure(c, fh, ea, 1'b1, 50, 20, 5);
    chk(ea == 1'b1, "R5 flag on N below 32", int'(ea), 1);
    chk(c == 3207, "R5 period unchanged", c, 3207);
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 3207, "R5 ratio kept after reject", c, 3207);
    measure(c, fh, ea, 1'b1, 50, 10, 12);
    chk(ea == 1'b1, "R5 flag on A above N", int'(ea), 1);
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 3207, "R5 ratio kept after second reject", c, 3207);
    chk(cfg_err == 1'b1, "R5 flag held", int'(cfg_err), 1);
  endtask

  task automatic t_accept_clears();
    int c; bit fh, ea;
    measure(c, fh, ea, 1'b1, 50, 32, 31);
    chk(ea == 1'b0, "R6 flag cleared by good load", int'(ea), 0);
    chk(c == 3207, "R4 running period kept", c, 3207);
    measure(c, fh, ea, 1'b1, 40, 33, 0);
    chk(c == 1055, "R1 N=32 A=31 spacing", c, 1055);
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 1056, "R1 N=33 A=0 spacing", c, 1056);
  endtask

  task automatic t_reset_restores();
    int c; bit fh, ea;
    measure(c, fh, ea, 1'b1, 30, 5, 1);
    chk(ea == 1'b1, "R5 flag before reset", int'(ea), 1);
    do_reset();
    chk(cfg_err == 1'b0, "R8 flag after reset", int'(cfg_err), 0);
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 1024, "R8 default ratio restored", c, 1024);
    measure(c, fh, ea, 1'b0, 0, 0, 0);
    chk(c == 1024, "R7 min ratio N=32 A=0", c, 1024);
  endtask

  initial begin
    t_first_after_reset();
    t_boundary_loads();
    t_rejected_offers();
    t_accept_clears();
    t_reset_restores();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule